// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block runs Clause 45 management transactions to an external PHY over a two-wire serial management bus. Software sees four 32-bit registers on a plain write-strobe port with a combinational read path. Three of these writes start a serial frame as a side effect:

- Writing the address register (offset 1) sends an address frame. It carries the register number together with the port and device fields already held in the command register.
- Writing the data register (offset 2) sends a write frame.
- Writing the command register (offset 0) with its read bit set sends a read frame.

Each frame is 64 bits long and is shifted out MSB first. A programmable divider sets the management clock. The master changes the data line only on the falling clock edge. During a read it releases the line from the first turnaround bit onward and samples the PHY on rising edges.

Software polls the configuration/status register (offset 3). The busy flag in that register must read clear before the next step. The error flag reports a PHY that did not pull the line low in the second turnaround bit of a read. While a frame is running, every register write is dropped.

Top module: `mdio_c45_master`

## Requirements
- R1: After reset, busy and error read 0, MDC and the output enable are low, and offset 3 reads the reset configuration: bits [6:0] = 0x48, divider = RESET_DIV at bits [7+DIV_W-1:7].
- R2: Writing offset 1 while idle sends the 64-bit address frame MSB first: 32 ones, start 00, opcode 00, port (command bits [9:5]), device (command bits [4:0]), turnaround 10, then the written value [15:0]. The value reads back at offset 1.
- R3: Writing offset 2 while idle sends the write frame. It is the same as R2 except that the opcode is 01 and the data field is the written value [15:0].
- R4: Writing offset 0 with bit 15 set while idle stores port and device from that write and sends a read frame with opcode 11. The output enable is low from bit 46 (the first turnaround bit) through bit 63. The 16 bits sampled on the last 16 rising MDC edges are placed, MSB first, in offset 2 bits [15:0]. Bit 15 of the command register is not held and reads back 0.
- R5: MDIO and its output enable change only on the clock edge that takes MDC low. They are stable while MDC is high.
- R6: MDC stays low when idle. While a frame runs, each MDC half period lasts max(divider,1) clock cycles.
- R7: Busy (offset 3 bit 31) is 1 in the cycle after a launching write. It clears exactly 128·max(divider,1) cycles after that write.
- R8: Error (offset 3 bit 30) is set when MDIO reads 1 at the rising MDC edge of the second turnaround bit of a read frame. It is cleared when the next frame is launched.
- R9: Any register write made while busy is dropped. The running frame, the stored registers and the configuration are unchanged, and no further frame starts.
- R10: Writing offset 3 while idle stores bits [6:0] and the divider at bits [7+DIV_W-1:7]. Both read back at offset 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register offset: 0 command, 1 address, 2 data, 3 configuration/status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe_o | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Management data in |

## Verification
The bench builds the block with DIV_W = 4 and RESET_DIV = 2, so one frame takes only 256 clock cycles. This makes it practical to check every frame bit by bit and to time the busy window to the exact cycle. The narrow divider also lets the bench program the values 3 and 0. This covers the zero-divider clamp and a non-default half period, both measured at MDC. A PHY model drives the turnaround and data bits, so a read with a good turnaround and a read with a failed turnaround are both exercised.

// File: rtl/mdio_c45_pkg.sv
package mdio_c45_pkg;

  localparam int FRAME_LEN = 64;
  localparam int TA_BIT    = 46;  // first turnaround bit of a frame
  localparam int DATA_BIT  = 48;  // first data bit of a frame
  localparam int PRE_LEN   = 32;

  localparam int CMD_RD_BIT  = 15;
  localparam int STAT_BUSY   = 31;
  localparam int STAT_ERR    = 30;
  localparam int CFG_LOW_W   = 7;
  localparam int CFG_DIV_LSB = 7;
  localparam logic [CFG_LOW_W-1:0] CFG_LOW_RST = 7'h48;

  typedef enum logic [1:0] {
    OP_ADDR  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    REG_CMD  = 2'd0,
    REG_ADDR = 2'd1,
    REG_DATA = 2'd2,
    REG_CFG  = 2'd3
  } reg_e;

  typedef struct packed {
    op_e         op;
    logic [4:0]  prt;
    logic [4:0]  dev;
    logic [15:0] payload;
  } launch_t;

  function automatic logic [FRAME_LEN-1:0] build_frame(launch_t l);
    return {{PRE_LEN{1'b1}}, 2'b00, l.op, l.prt, l.dev, 2'b10, l.payload};
  endfunction

endpackage

// File: rtl/mdio_c45_clkgen.sv
module mdio_c45_clkgen #(
  parameter int DIV_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_eff;
  logic             mdc_q;
  logic             term;

  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
  assign term    = run_i && (cnt_q == div_eff - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (term) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  assign mdc_o  = mdc_q;
  assign rise_o = term && !mdc_q;
  assign fall_o = term && mdc_q;

  p_toggle_needs_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_q != $past(mdc_q)) |-> $past(run_i));

endmodule

// File: rtl/mdio_c45_shifter.sv
module mdio_c45_shifter
  import mdio_c45_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  launch_t     launch_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic        err_o,
  output logic        rd_done_o,
  output logic [15:0] rd_data_o
);

  localparam int CNT_W = $clog2(FRAME_LEN);

  logic                 busy_q;
  logic                 rd_q;
  logic                 err_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [FRAME_LEN-1:0] sh_q;
  logic [15:0]          data_q;
  logic                 last;

  assign last = fall_i && (cnt_q == CNT_W'(FRAME_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      err_q  <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '1;
      data_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      rd_q   <= (launch_i.op == OP_READ);
      err_q  <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= build_frame(launch_i);
    end else if (busy_q) begin
      if (fall_i) begin
        if (last) begin
          busy_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + CNT_W'(1);
          sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b1};
        end
      end
      if (rise_i && rd_q) begin
        if (cnt_q == CNT_W'(TA_BIT + 1)) begin
          err_q <= mdio_i;  // PHY must pull low here
        end else if (cnt_q >= CNT_W'(DATA_BIT)) begin
          data_q <= {data_q[14:0], mdio_i};
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign mdio_o    = busy_q ? sh_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe_o = busy_q && !(rd_q && (cnt_q >= CNT_W'(TA_BIT)));
  assign err_o     = err_q;
  assign rd_done_o = busy_q && rd_q && last;
  assign rd_data_o = data_q;

  p_err_clear_on_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !err_o);

  p_done_ends_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_o |=> !busy_o);

endmodule

// File: rtl/mdio_c45_regs.sv
module mdio_c45_regs
  import mdio_c45_pkg::*;
#(
  parameter int DIV_W     = 9,
  parameter int RESET_DIV = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             busy_i,
  input  logic             err_i,
  input  logic             rd_done_i,
  input  logic [15:0]      rd_data_i,
  output logic             start_o,
  output launch_t          launch_o,
  output logic [DIV_W-1:0] div_o
);

  logic [4:0]           prt_q, dev_q;
  logic [15:0]          addr_q, data_q;
  logic [CFG_LOW_W-1:0] cfg_low_q;
  logic [DIV_W-1:0]     div_q;
  logic                 idle_we;
  logic [31:0]          status;
  logic                 unused_wdata;

  assign idle_we      = we_i && !busy_i;
  assign unused_wdata = ^wdata_i[31:16];

  always_comb begin
    start_o          = 1'b0;
    launch_o.op      = OP_ADDR;
    launch_o.prt     = prt_q;
    launch_o.dev     = dev_q;
    launch_o.payload = wdata_i[15:0];
    unique case (reg_e'(addr_i))
      REG_ADDR: start_o = idle_we;
      REG_DATA: begin
        launch_o.op = OP_WRITE;
        start_o     = idle_we;
      end
      REG_CMD: begin
        launch_o.op      = OP_READ;
        launch_o.prt     = wdata_i[9:5];
        launch_o.dev     = wdata_i[4:0];
        launch_o.payload = '1;
        start_o          = idle_we && wdata_i[CMD_RD_BIT];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prt_q     <= '0;
      dev_q     <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      cfg_low_q <= CFG_LOW_RST;
      div_q     <= DIV_W'(RESET_DIV);
    end else if (idle_we) begin
      unique case (reg_e'(addr_i))
        REG_CMD: begin
          prt_q <= wdata_i[9:5];
          dev_q <= wdata_i[4:0];
        end
        REG_ADDR: addr_q <= wdata_i[15:0];
        REG_DATA: data_q <= wdata_i[15:0];
        REG_CFG: begin
          cfg_low_q <= wdata_i[CFG_LOW_W-1:0];
          div_q     <= wdata_i[CFG_DIV_LSB +: DIV_W];
        end
        default: ;
      endcase
    end else if (rd_done_i) begin
      data_q <= rd_data_i;
    end
  end

  always_comb begin
    status                          = '0;
    status[CFG_LOW_W-1:0]           = cfg_low_q;
    status[CFG_DIV_LSB +: DIV_W]    = div_q;
    status[STAT_BUSY]               = busy_i;
    status[STAT_ERR]                = err_i;
  end

  always_comb begin
    unique case (reg_e'(addr_i))
      REG_CMD:  rdata_o = {22'b0, prt_q, dev_q};
      REG_ADDR: rdata_o = {16'b0, addr_q};
      REG_DATA: rdata_o = {16'b0, data_q};
      default:  rdata_o = status;
    endcase
  end

  assign div_o = div_q;

  p_done_only_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_done_i |-> busy_i);

endmodule

// File: rtl/mdio_c45_master.sv
module mdio_c45_master
  import mdio_c45_pkg::*;
#(
  parameter int DIV_W     = 9,
  parameter int RESET_DIV = 20
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);

  logic             busy, err, rd_done, start, rise, fall;
  logic [15:0]      rd_data;
  logic [DIV_W-1:0] div;
  launch_t          launch;

  mdio_c45_regs #(
    .DIV_W    (DIV_W),
    .RESET_DIV(RESET_DIV)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .busy_i   (busy),
    .err_i    (err),
    .rd_done_i(rd_done),
    .rd_data_i(rd_data),
    .start_o  (start),
    .launch_o (launch),
    .div_o    (div)
  );

  mdio_c45_clkgen #(
    .DIV_W(DIV_W)
  ) u_clkgen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .div_i (div),
    .mdc_o (mdc_o),
    .rise_o(rise),
    .fall_o(fall)
  );

  mdio_c45_shifter u_shifter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .launch_i (launch),
    .rise_i   (rise),
    .fall_i   (fall),
    .mdio_i   (mdio_i),
    .busy_o   (busy),
    .mdio_o   (mdio_o),
    .mdio_oe_o(mdio_oe_o),
    .err_o    (err),
    .rd_done_o(rd_done),
    .rd_data_o(rd_data)
  );

  p_hold_while_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

  p_idle_mdc_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mdc_o);

  p_oe_only_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> busy);

  p_launch_needs_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> ($past(reg_we_i) && !$past(busy)));

endmodule

// File: tb/mdio_c45_master_bench.sv
`timescale 1ns/1ps
module mdio_c45_master_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int hold_viol = 0;
  int nbit = 0;
  bit finished = 1'b0;
  logic [63:0] cap = '0;
  logic [63:0] oemap = '0;
  logic [17:0] resp = '1;

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  mdio_c45_master #(.DIV_W(4), .RESET_DIV(2)) u_mdio_c45_master (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe), .mdio_i(mdio_i)
  );

  // PHY model: samples on rising MDC, drives turnaround/data after falling MDC
  always @(posedge mdc) begin
    cap   = {cap[62:0], mdio_oe ? mdio_o : mdio_i};
    oemap = {oemap[62:0], mdio_oe};
    nbit  = (nbit + 1) % 64;
  end
  always @(negedge mdc) mdio_i = (nbit >= 46) ? resp[63 - nbit] : 1'b1;
  always @(mdio_o or mdio_oe) if (mdc === 1'b1) hold_viol++;

  function automatic logic [63:0] frame(logic [1:0] op, logic [4:0] p, logic [4:0] d,
                                        logic [15:0] v);
    return {32'hFFFF_FFFF, 2'b00, op, p, d, 2'b10, v};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    do begin
      @(negedge clk);
      rd(2'd3, v);
    end while (v[31]);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd3, v);
    chk("R1 status", v, 32'h0000_0148);
    chk("R1 mdc/oe", {mdc, mdio_oe}, 2'b00);
  endtask

  task automatic t_cfg_period();
    logic [31:0] v;
    int t0;
    wr(2'd3, 32'h0000_01C8);
    rd(2'd3, v);
    chk("R10 cfg readback", v, 32'h0000_01C8);
    wr(2'd1, 32'h0);
    @(posedge mdc); t0 = cyc;
    @(posedge mdc);
    chk("R6 period div3", 64'(cyc - t0), 64'd6);
    wait_idle();
    wr(2'd3, 32'h0000_0048);
    wr(2'd1, 32'h0);
    @(posedge mdc); t0 = cyc;
    @(posedge mdc);
    chk("R6 period div0", 64'(cyc - t0), 64'd2);
    wait_idle();
    wr(2'd3, 32'h0000_0148);
    chk("R6 idle mdc", {63'b0, mdc}, 64'd0);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    int t0;
    wr(2'd0, 32'h0000_003E);
    rd(2'd0, v);
    chk("R2 cmd readback", v, 32'h3E);
    wr(2'd1, 32'h0000_A5C3);
    t0 = cyc;
    rd(2'd3, v);
    chk("R7 busy after launch", {63'b0, v[31]}, 64'd1);
    wait_idle();
    chk("R7 busy length", 64'(cyc - t0), 64'd256);
    chk("R2 frame", cap, frame(2'b00, 5'h01, 5'h1E, 16'hA5C3));
    chk("R2 oe", oemap, '1);
    rd(2'd1, v);
    chk("R2 addr readback", v, 32'hA5C3);
  endtask

  task automatic t_write();
    logic [31:0] v;
    resp = '1;
    wr(2'd2, 32'h0000_1234);
    wait_idle();
    chk("R3 frame", cap, frame(2'b01, 5'h01, 5'h1E, 16'h1234));
    rd(2'd2, v);
    chk("R3 data readback", v, 32'h1234);
  endtask

  task automatic t_read();
    logic [31:0] v;
    resp = {1'b1, 1'b0, 16'hBEEF};
    wr(2'd0, 32'h0000_83E7);
    wait_idle();
    chk("R4 header", {18'b0, cap[63:18]}, {18'b0, frame(2'b11, 5'h1F, 5'h07, 16'h0)} >> 18);
    chk("R4 data on line", {48'b0, cap[15:0]}, 64'hBEEF);
    chk("R4 oe release", oemap, 64'hFFFF_FFFF_FFFC_0000);
    rd(2'd2, v);
    chk("R4 data reg", v, 32'hBEEF);
    rd(2'd0, v);
    chk("R4 cmd read bit clear", v, 32'h3E7);
    rd(2'd3, v);
    chk("R8 no error", {63'b0, v[30]}, 64'd0);
  endtask

  task automatic t_err();
    logic [31:0] v;
    resp = {1'b1, 1'b1, 16'h5A5A};
    wr(2'd0, 32'h0000_83E7);
    wait_idle();
    rd(2'd3, v);
    chk("R8 error set", {63'b0, v[30]}, 64'd1);
    rd(2'd2, v);
    chk("R8 data reg", v, 32'h5A5A);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    resp = '1;
    wr(2'd0, 32'h0000_0021);
    wr(2'd1, 32'h0000_0F0F);
    rd(2'd3, v);
    chk("R8 error cleared on launch", {62'b0, v[31:30]}, 64'd2);
    repeat (40) @(negedge clk);
    wr(2'd2, 32'h0000_DEAD);
    wr(2'd0, 32'h0000_83FF);
    wr(2'd3, 32'h0000_007F);
    wr(2'd1, 32'h0000_1111);
    wait_idle();
    chk("R9 frame intact", cap, frame(2'b00, 5'h01, 5'h01, 16'h0F0F));
    rd(2'd2, v);
    chk("R9 data kept", v, 32'h5A5A);
    rd(2'd0, v);
    chk("R9 cmd kept", v, 32'h21);
    rd(2'd1, v);
    chk("R9 addr kept", v, 32'h0F0F);
    rd(2'd3, v);
    chk("R9 cfg kept", v, 32'h148);
    repeat (40) @(negedge clk);
    chk("R9 no extra frame", {62'b0, mdc, mdio_oe}, 64'd0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg_period();
    t_addr();
    t_write();
    t_read();
    t_err();
    t_busy_ignore();
    chk("R5 no change while mdc high", 64'(hold_viol), 64'd0);
    finish_run();
  end

endmodule